// File: doc/BRIEF.md
# AUX Link-Training Setting Snooper

This block sits beside a DisplayPort AUX channel listener and watches the framed byte stream that the listener recovers from both directions of the channel. It parses native write requests from the source and the reply that the sink returns. It picks out every byte whose address is the lane-count register or one of the per-lane training-control registers, and it uses them to drive a repeater's analog front end: which main-link lanes are switched on, and what swing and pre-emphasis code each lane drives.

A write is only held as a candidate until the sink answers. The candidate bytes sit in shadow storage. They are copied to the live outputs only when the first byte of the next reply frame carries the acknowledge code. A refused or deferred reply throws them away. The stored settings have no meaningful value after power-up, so each group of outputs carries its own valid flag, and that flag stays low until the first accepted write that covers the group.

The input is a valid/ready byte stream with start-of-frame and end-of-frame markers and a direction bit. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. The block applies no back-pressure: `in_ready` is low only while reset is applied, so the listener may hold a byte for as long as it likes but never has to wait.

Top module: `aux_lt_snoop`

## Requirements
- R1: While reset is applied and right after it, `lane_cnt_valid`, `lane_en`, `lane_set_valid`, `drive_lvl`, `drive_max`, `preemph_lvl` and `preemph_max` are all zero.
- R2: A request frame begins with a 4-byte header. Byte 0 holds the command in bits 7:4 (1000b means native write) and address bits 19:16 in bits 3:0. Byte 1 holds address bits 15:8, byte 2 holds address bits 7:0, and byte 3 holds the number of data bytes minus one. The data bytes follow.
- R3: An accepted lane count sets `lane_en`. A count of 1 enables lane 0 (0001b), 2 enables lanes 0 and 1 (0011b), and 4 enables all lanes (1111b). The count is taken from bits 3:0 of the byte written to address 00101h; bits 7:4 of that byte are ignored.
- R4: A lane-count byte whose bits 3:0 are not 1, 2 or 4 is dropped, and the previous live count is kept.
- R5: The byte written to address 00103h+i configures lane i. Its bits 1:0 go to `drive_lvl[2i+1:2i]`, bit 2 to `drive_max[i]`, bits 4:3 to `preemph_lvl[2i+1:2i]` and bit 5 to `preemph_max[i]`. Bits 7:6 are ignored.
- R6: Live outputs change only in the cycle after the first byte of a reply frame is accepted, and only if bits 7:4 of that byte are 0000b (ACK) and a complete write request came before it. Until then, the outputs keep their old values.
- R7: If the reply code is anything other than ACK (for example NACK 0001b or DEFER 0010b), the staged write is discarded and the live outputs stay the same.
- R8: The address increments by one for each data byte in a burst, so one burst updates every covered register. Bytes whose full 20-bit address is not one of the snooped registers (including 00102h) are ignored.
- R9: Requests with any command other than native write stage nothing. When a new request frame starts, any staged write that has not yet been committed is discarded.
- R10: `lane_cnt_valid` and each `lane_set_valid[i]` go high at the first commit of their register and stay high until reset. `lane_en` is zero while `lane_cnt_valid` is low.
- R11: Data bytes beyond the count given in the length byte are ignored.
- R12: `in_ready` is low during reset and high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte present on the stream |
| in_ready | output | 1 | Block accepts bytes (high outside reset) |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_is_reply | input | 1 | Frame travels from sink to source (reply) |
| lane_cnt_valid | output | 1 | A legal lane count has been committed |
| lane_en | output | LANES | Per-lane enable derived from the lane count |
| lane_set_valid | output | LANES | Per-lane training setting has been committed |
| drive_lvl | output | 2*LANES | Per-lane swing level, 2 bits per lane |
| drive_max | output | LANES | Per-lane maximum-swing flag |
| preemph_lvl | output | 2*LANES | Per-lane pre-emphasis level, 2 bits per lane |
| preemph_max | output | LANES | Per-lane maximum-pre-emphasis flag |

## Verification
The hardest case to reach from the ports is a write that has been fully staged but then never commits. This happens when a NACK or DEFER reply arrives, when a new request supersedes the staged write, or when the staged bytes include ones that the length byte excludes. To reach it, the stimulus builds complete request frames with chosen lengths and extra trailing bytes, and then pairs them with refused replies or follows them with another request before any reply. The outputs are checked both before and after the reply against a model updated only on acknowledged writes. Bursts that start below the snooped window and straddle the unused address 00102h confirm that the auto-increment lines up exactly.

// File: rtl/aux_snoop_pkg.sv
package aux_snoop_pkg;
  localparam int ADDR_W    = 20;
  localparam int HDR_BYTES = 4;

  localparam logic [3:0] CMD_NATIVE_WR = 4'b1000;
  localparam logic [3:0] RPL_ACK       = 4'b0000;

  // Bit order mirrors the per-lane training byte (bit 5 down to bit 0).
  typedef struct packed {
    logic       pre_max;
    logic [1:0] pre_lvl;
    logic       drv_max;
    logic [1:0] drv_lvl;
  } lane_set_t;
endpackage

// File: rtl/aux_frame_parser.sv
module aux_frame_parser
  import aux_snoop_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [7:0]        data,
  input  logic              sof,
  input  logic              eof,
  input  logic              is_reply,
  output logic              req_sof,
  output logic              rep_sof,
  output logic [3:0]        rep_code,
  output logic              wr_vld,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_end
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_HDR = IDX_W'(HDR_BYTES);

  logic [IDX_W-1:0]  idx_q, idx_cur, off;
  logic              rep_q, rep_cur;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        len_q;
  logic              is_wr;

  always_comb begin
    idx_cur  = sof ? '0 : idx_q;
    rep_cur  = sof ? is_reply : rep_q;
    off      = idx_cur - IDX_HDR;
    is_wr    = (cmd_q == CMD_NATIVE_WR);
    req_sof  = fire & sof & ~is_reply;
    rep_sof  = fire & sof & is_reply;
    rep_code = data[7:4];
    wr_vld   = fire & ~rep_cur & (idx_cur >= IDX_HDR) & is_wr &
               (off <= IDX_W'(len_q));
    wr_addr  = addr_q + ADDR_W'(off);
    wr_data  = data;
    wr_end   = fire & eof & ~rep_cur & (idx_cur >= IDX_HDR - 1'b1) & is_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= IDX_MAX;
      rep_q  <= 1'b1;
      cmd_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
    end else if (fire) begin
      rep_q <= rep_cur;
      idx_q <= (idx_cur == IDX_MAX) ? IDX_MAX : idx_cur + 1'b1;
      if (!rep_cur) begin
        if (idx_cur == IDX_W'(0)) begin
          cmd_q                      <= data[7:4];
          addr_q[ADDR_W-1 -: 4]      <= data[3:0];
        end else if (idx_cur == IDX_W'(1)) begin
          addr_q[15:8] <= data;
        end else if (idx_cur == IDX_W'(2)) begin
          addr_q[7:0] <= data;
        end else if (idx_cur == IDX_W'(3)) begin
          len_q <= data;
        end
      end
    end
  end
endmodule

// File: rtl/aux_shadow_stage.sv
module aux_shadow_stage
  import aux_snoop_pkg::*;
#(
  parameter int                LANES     = 4,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 20'h00101,
  parameter logic [ADDR_W-1:0] LANE_BASE = 20'h00103
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_sof,
  input  logic                    rep_sof,
  input  logic                    wr_vld,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    wr_end,
  output logic                    pend,
  output logic                    stg_cnt_vld,
  output logic [3:0]              stg_cnt,
  output logic [LANES-1:0]        stg_lane_vld,
  output lane_set_t [LANES-1:0]   stg_lane
);
  logic flush;
  assign flush = req_sof | rep_sof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      stg_cnt_vld <= 1'b0;
      stg_cnt     <= '0;
    end else begin
      if (flush)       pend <= 1'b0;
      else if (wr_end) pend <= 1'b1;

      if (flush) begin
        stg_cnt_vld <= 1'b0;
      end else if (wr_vld && wr_addr == CNT_ADDR) begin
        stg_cnt_vld <= 1'b1;
        stg_cnt     <= wr_data[3:0];
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit;
    assign hit = wr_vld && (wr_addr == LANE_BASE + ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_lane_vld[i] <= 1'b0;
        stg_lane[i]     <= '0;
      end else if (flush) begin
        stg_lane_vld[i] <= 1'b0;
      end else if (hit) begin
        stg_lane_vld[i] <= 1'b1;
        stg_lane[i]     <= lane_set_t'(wr_data[5:0]);
      end
    end
  end
endmodule

// File: rtl/aux_live_regs.sv
module aux_live_regs
  import aux_snoop_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rep_sof,
  input  logic [3:0]            rep_code,
  input  logic                  pend,
  input  logic                  stg_cnt_vld,
  input  logic [3:0]            stg_cnt,
  input  logic [LANES-1:0]      stg_lane_vld,
  input  lane_set_t [LANES-1:0] stg_lane,
  output logic                  cnt_vld,
  output logic [LANES-1:0]      lane_en,
  output logic [LANES-1:0]      lane_vld,
  output lane_set_t [LANES-1:0] live_lane
);
  localparam logic [4:0] MAX_CNT = 5'(LANES);

  logic       commit, cnt_ok;
  logic [3:0] cnt_q;

  assign commit = rep_sof & pend & (rep_code == RPL_ACK);
  assign cnt_ok = stg_cnt_vld && $onehot(stg_cnt) && ({1'b0, stg_cnt} <= MAX_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_vld <= 1'b0;
      cnt_q   <= '0;
    end else if (commit && cnt_ok) begin
      cnt_vld <= 1'b1;
      cnt_q   <= stg_cnt;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = cnt_vld && ({1'b0, cnt_q} > 5'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_vld[i]  <= 1'b0;
        live_lane[i] <= '0;
      end else if (commit && stg_lane_vld[i]) begin
        lane_vld[i]  <= 1'b1;
        live_lane[i] <= stg_lane[i];
      end
    end
  end
endmodule

// File: rtl/aux_lt_snoop.sv
module aux_lt_snoop
  import aux_snoop_pkg::*;
#(
  parameter int                LANES     = 4,
  parameter int                IDX_W     = 10,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 20'h00101,
  parameter logic [ADDR_W-1:0] LANE_BASE = 20'h00103
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic                 in_is_reply,
  output logic                 lane_cnt_valid,
  output logic [LANES-1:0]     lane_en,
  output logic [LANES-1:0]     lane_set_valid,
  output logic [2*LANES-1:0]   drive_lvl,
  output logic [LANES-1:0]     drive_max,
  output logic [2*LANES-1:0]   preemph_lvl,
  output logic [LANES-1:0]     preemph_max
);
  logic              ready_q, fire;
  logic              req_sof, rep_sof, wr_vld, wr_end, pend;
  logic [3:0]        rep_code, stg_cnt;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              stg_cnt_vld;
  logic [LANES-1:0]  stg_lane_vld;
  lane_set_t [LANES-1:0] stg_lane, live_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;
  assign fire     = in_valid & ready_q;

  aux_frame_parser #(.IDX_W(IDX_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .data(in_data), .sof(in_sof),
    .eof(in_eof), .is_reply(in_is_reply), .req_sof(req_sof), .rep_sof(rep_sof),
    .rep_code(rep_code), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_end(wr_end)
  );

  aux_shadow_stage #(.LANES(LANES), .CNT_ADDR(CNT_ADDR), .LANE_BASE(LANE_BASE)) u_stage (
    .clk(clk), .rst_n(rst_n), .req_sof(req_sof), .rep_sof(rep_sof),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data), .wr_end(wr_end),
    .pend(pend), .stg_cnt_vld(stg_cnt_vld), .stg_cnt(stg_cnt),
    .stg_lane_vld(stg_lane_vld), .stg_lane(stg_lane)
  );

  aux_live_regs #(.LANES(LANES)) u_live (
    .clk(clk), .rst_n(rst_n), .rep_sof(rep_sof), .rep_code(rep_code), .pend(pend),
    .stg_cnt_vld(stg_cnt_vld), .stg_cnt(stg_cnt), .stg_lane_vld(stg_lane_vld),
    .stg_lane(stg_lane), .cnt_vld(lane_cnt_valid), .lane_en(lane_en),
    .lane_vld(lane_set_valid), .live_lane(live_lane)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign drive_lvl[2*i +: 2]   = live_lane[i].drv_lvl;
    assign drive_max[i]          = live_lane[i].drv_max;
    assign preemph_lvl[2*i +: 2] = live_lane[i].pre_lvl;
    assign preemph_max[i]        = live_lane[i].pre_max;
  end
endmodule

// File: rtl/aux_lt_snoop_chk.sv
module aux_lt_snoop_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [7:0]         in_data,
  input logic               in_sof,
  input logic               in_is_reply,
  input logic               lane_cnt_valid,
  input logic [LANES-1:0]   lane_en,
  input logic [LANES-1:0]   lane_set_valid,
  input logic [2*LANES-1:0] drive_lvl,
  input logic [LANES-1:0]   drive_max,
  input logic [2*LANES-1:0] preemph_lvl,
  input logic [LANES-1:0]   preemph_max
);
  logic rep_head;
  assign rep_head = in_valid && in_ready && in_sof && in_is_reply;

  a_r3_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en & (lane_en + {{(LANES-1){1'b0}}, 1'b1})) == '0);

  a_r10_mask_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_cnt_valid |-> lane_en == '0);

  a_r10_count_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lane_cnt_valid |=> lane_cnt_valid);

  a_r7_refusal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_head && in_data[7:4] != 4'h0) |=>
      ($stable(lane_en) && $stable(lane_set_valid) && $stable(drive_lvl) &&
       $stable(preemph_lvl) && $stable(drive_max) && $stable(preemph_max)));

  a_r6_change_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lane_set_valid) || !$stable(drive_lvl) || !$stable(preemph_lvl) ||
     !$stable(drive_max) || !$stable(preemph_max) || !$stable(lane_cnt_valid)) |->
      $past(rep_head));

  a_r12_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

bind aux_lt_snoop aux_lt_snoop_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_sof(in_sof), .in_is_reply(in_is_reply),
  .lane_cnt_valid(lane_cnt_valid), .lane_en(lane_en),
  .lane_set_valid(lane_set_valid), .drive_lvl(drive_lvl), .drive_max(drive_max),
  .preemph_lvl(preemph_lvl), .preemph_max(preemph_max)
);

// File: tb/aux_lt_snoop_tb_top.sv
`timescale 1ns/1ps
module aux_lt_snoop_tb_top;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_is_reply = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, lane_cnt_valid;
  logic [NL-1:0] lane_en, lane_set_valid, drive_max, preemph_max;
  logic [2*NL-1:0] drive_lvl, preemph_lvl;

  always #5 clk = ~clk;

  aux_lt_snoop #(.LANES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_is_reply(in_is_reply),
    .lane_cnt_valid(lane_cnt_valid), .lane_en(lane_en), .lane_set_valid(lane_set_valid),
    .drive_lvl(drive_lvl), .drive_max(drive_max), .preemph_lvl(preemph_lvl),
    .preemph_max(preemph_max)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // Model of committed state, updated only from the requirements.
  bit         m_lcv;
  logic [3:0] m_lc;
  bit   [NL-1:0] m_lsv;
  logic [5:0] m_lane [NL];
  // Last request seen, waiting for a reply.
  bit          r_pend;
  logic [3:0]  r_cmd;
  logic [19:0] r_addr;
  int          r_n;
  logic [47:0] r_data;

  // {addr[19:0], byte count[3:0], data bytes (byte 0 lowest)[47:0], reply code[3:0]}
  localparam int NV = 10;
  localparam logic [75:0] VEC [NV] = '{
    {20'h00103, 4'd4, 48'h00002C130A01, 4'h0},  // R5 all four lanes, ACK
    {20'h00101, 4'd1, 48'h000000000002, 4'h0},  // R3 two lanes
    {20'h00101, 4'd1, 48'h000000000004, 4'h1},  // R7 NACK
    {20'h00101, 4'd1, 48'h000000000003, 4'h0},  // R4 illegal count
    {20'h00101, 4'd6, 48'h2211003F99F4, 4'h0},  // R8 burst over 101..106, R3 upper nibble
    {20'h00102, 4'd3, 48'h000000180755, 4'h2},  // R7 DEFER
    {20'h00104, 4'd2, 48'h00000000DB24, 4'h0},  // R5 bits 7:6 ignored
    {20'h00100, 4'd2, 48'h000000000101, 4'h0},  // R8 start below window, one lane
    {20'h00200, 4'd2, 48'h000000000404, 4'h0},  // R8 unrelated address
    {20'h10101, 4'd1, 48'h000000000004, 4'h0}   // R2 upper address nibble matters
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lcv = 1'b0; m_lc = '0; m_lsv = '0; r_pend = 1'b0;
    for (int i = 0; i < NL; i++) m_lane[i] = '0;
  endtask

  task automatic model_apply();
    for (int k = 0; k < r_n; k++) begin
      logic [19:0] a;
      logic [7:0]  d;
      a = r_addr + 20'(k);
      d = r_data[8*k +: 8];
      if (a == 20'h00101 && (d[3:0] == 4'd1 || d[3:0] == 4'd2 || d[3:0] == 4'd4)) begin
        m_lcv = 1'b1; m_lc = d[3:0];
      end
      for (int i = 0; i < NL; i++)
        if (a == 20'h00103 + 20'(i)) begin
          m_lsv[i] = 1'b1; m_lane[i] = d[5:0];
        end
    end
  endtask

  task automatic check_all(input string tag);
    logic [NL-1:0] exp_en;
    #4;
    exp_en = '0;
    for (int i = 0; i < NL; i++) exp_en[i] = m_lcv && (i < int'(m_lc));
    chk(lane_cnt_valid == m_lcv, {tag, " R10 count valid"}, 32'(lane_cnt_valid), 32'(m_lcv));
    chk(lane_en == exp_en, {tag, " R3 lane mask"}, 32'(lane_en), 32'(exp_en));
    chk(lane_set_valid == m_lsv, {tag, " R10 lane valid"}, 32'(lane_set_valid), 32'(m_lsv));
    for (int i = 0; i < NL; i++) begin
      logic [5:0] act;
      act = {preemph_max[i], preemph_lvl[2*i +: 2], drive_max[i], drive_lvl[2*i +: 2]};
      chk(act == m_lane[i], {tag, " R5 lane setting"}, 32'(act), 32'(m_lane[i]));
    end
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic e, input logic r);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_is_reply = r;
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_is_reply = 1'b0;
  endtask

  task automatic send_req(input logic [3:0] cmd, input logic [19:0] a, input logic [7:0] len,
                          input int nb, input logic [47:0] d);
    put({cmd, a[19:16]}, 1'b1, 1'b0, 1'b0);
    put(a[15:8], 1'b0, 1'b0, 1'b0);
    put(a[7:0], 1'b0, 1'b0, 1'b0);
    put(len, 1'b0, nb == 0, 1'b0);
    for (int k = 0; k < nb; k++) put(d[8*k +: 8], 1'b0, k == nb - 1, 1'b0);
    r_pend = 1'b1; r_cmd = cmd; r_addr = a; r_data = d;
    r_n = (nb < int'(len) + 1) ? nb : int'(len) + 1;
  endtask

  task automatic send_reply(input logic [3:0] code);
    put({code, 4'h0}, 1'b1, 1'b1, 1'b1);
    if (r_pend && code == 4'h0 && r_cmd == 4'b1000) model_apply();
    r_pend = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    chk(in_ready == 1'b0, "R12 ready low in reset", 32'(in_ready), 0);
    check_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    check_all("R1 after reset");
    chk(in_ready == 1'b1, "R12 ready high", 32'(in_ready), 1);

    // R6 reply with nothing pending
    send_reply(4'h0);
    check_all("R6 lone reply");

    // R2 table of write bursts with their replies
    for (int n = 0; n < NV; n++) begin
      logic [75:0] v;
      v = VEC[n];
      send_req(4'b1000, v[75:56], 8'(v[55:52] - 4'd1), int'(v[55:52]), v[51:4]);
      check_all("R6 before reply");
      send_reply(v[3:0]);
      check_all("R2 after reply");
    end

    // R9 read command carrying trailing bytes
    send_req(4'b1001, 20'h00101, 8'h00, 1, 48'h2);
    send_reply(4'h0);
    check_all("R9 read");

    // R9 staged write superseded by a new request before any reply
    send_req(4'b1000, 20'h00101, 8'h00, 1, 48'h4);
    send_req(4'b1000, 20'h00200, 8'h00, 1, 48'h0);
    send_reply(4'h0);
    check_all("R9 superseded");

    // R11 second byte lies past the length
    send_req(4'b1000, 20'h00103, 8'h00, 2, 48'h2A15);
    send_reply(4'h0);
    check_all("R11 extra byte");

    // R1 reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    model_reset();
    check_all("R1 second reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    send_req(4'b1000, 20'h00101, 8'h00, 1, 48'h1);
    send_reply(4'h0);
    check_all("R10 count after reset");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule